// File: doc/BRIEF.md
# Single-Byte Serial Peripheral Master

This block moves one byte over a four-wire serial link (the select line is handled elsewhere) each time software asks. A write to the data register loads the transmit byte and starts a transfer after a fixed three-clock launch delay. The block then produces eight serial clock cycles. Their idle level and phase come from two configuration bits, and their half-period comes from the `half_div` input. It shifts the byte out most significant bit first on `mosi` and collects eight bits from `miso`. At the end it stores the received byte, raises a done flag one clock later, and asserts `irq` if the interrupt is enabled. A write is needed even when only receiving.

Register map (`addr`): 0 is the data register; a write loads the transmit byte and reading returns the receive buffer. 1 is control/status: bit 0 clock polarity (idle level), bit 1 clock phase, bit 2 done-interrupt enable, bit 3 done (read; writing 1 clears), bit 4 busy (read only).

The controller has four states. `ST_IDLE` waits for a data write and then goes to `ST_LAUNCH`. `ST_LAUNCH` counts the launch delay and then goes to `ST_RUN`. `ST_RUN` steps through sixteen half-periods and goes to `ST_FINISH` when the last one expires. `ST_FINISH` sets done and returns to `ST_IDLE`.

Top module: `spi_byte_master`

## Requirements
- R1: A transfer starts only on a write to address 0 while idle. Control writes and reads never start one.
- R2: Outside a transfer, `sck` rests at the polarity bit (control bit 0).
- R3: The first output activity appears in the third clock after the write edge. At that point `mosi` carries bit 7. With phase 1, `sck` goes to its active level in that clock. With phase 0, `sck` stays idle for one more half-period.
- R4: `mosi` is held at 1 before and after every transfer.
- R5: Each `sck` half-period lasts `half_div` clocks, and 0 acts as 1. A transfer makes exactly 16 `sck` transitions.
- R6: Bits go out most significant first. `mosi` changes on the shifting edge and `miso` is captured on the sampling edge: the leading edge for phase 0, the trailing edge for phase 1.
- R7: The received byte is readable at address 0 when the eighth `sck` cycle ends. Done (control bit 3) follows one clock later, which is 16·H+4 clocks after the write edge.
- R8: `irq` is high exactly while done is set and enable (control bit 2) is 1.
- R9: Done clears on a read of address 0, or on a write of 1 to control bit 3.
- R10: A data write during a transfer is ignored. The byte on the wire is unchanged and no second transfer follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 1 | Register select (0 data, 1 control/status) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register |
| half_div | input | 8 | SCK half-period in system clocks |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Done interrupt |

## Verification
The assertions assume that register strobes last one clock and that `half_div` and `miso` change only between system clock edges. The bench drives every input at the falling clock edge. It plays the far-end device from the observed `sck` edges: it moves `miso` only after a sampling edge, so the line is stable whenever the block captures it. Phase and polarity are changed only while the block is idle.

// File: rtl/spi_byte_pkg.sv
package spi_byte_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LAUNCH,
        ST_RUN,
        ST_FINISH
    } xfer_state_t;
endpackage

// File: rtl/spi_phase_timer.sv
module spi_phase_timer #(
    parameter int DIVW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            en,
    input  logic [DIVW-1:0] limit,
    output logic            tick
);
    localparam logic [DIVW-1:0] ONE = DIVW'(1);
    logic [DIVW-1:0] cnt_q;

    assign tick = en && (cnt_q == limit - ONE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (clr)    cnt_q <= '0;
        else if (en)     cnt_q <= tick ? '0 : cnt_q + ONE;
    end
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         sample,
    input  logic         din,
    output logic         tx_msb,
    output logic         tx_next,
    output logic [W-1:0] rx_word
);
    logic [W-1:0] tx_q;
    logic [W-1:0] rx_q;

    assign tx_msb  = tx_q[W-1];
    assign tx_next = tx_q[W-2];
    assign rx_word = rx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= '1;
            rx_q <= '0;
        end else begin
            if (load)       tx_q <= load_val;
            else if (shift) tx_q <= {tx_q[W-2:0], 1'b1};
            if (sample)     rx_q <= {rx_q[W-2:0], din};
        end
    end
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
    import spi_byte_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int DIVW      = 8,
    parameter int START_LAT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [DIVW-1:0]   half_div,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic              irq
);
    localparam int HALVES = 2 * DATA_W;
    localparam int HW     = $clog2(HALVES);
    localparam int LW     = $clog2(START_LAT + 1);
    localparam logic [HW-1:0] LAST_HALF = HW'(HALVES - 1);
    localparam logic [HW-1:0] HONE      = HW'(1);
    localparam logic [LW-1:0] LAT_END   = LW'(START_LAT - 1);
    localparam logic [LW-1:0] LONE      = LW'(1);

    xfer_state_t state, state_nx;

    logic            cpol_q, cpha_q, ie_q, done_q;
    logic            sck_q, mosi_q;
    logic [LW-1:0]   lat_q;
    logic [HW-1:0]   half_q;
    logic [HW-1:0]   half_nx;
    logic [DIVW-1:0] div_q;
    logic [DATA_W-1:0] rx_buf_q;

    logic data_wr, ctrl_wr, done_clr, lat_done, tick, last_half;
    logic do_shift, do_sample, tx_msb, tx_next, busy;
    logic [DATA_W-1:0] rx_word;

    assign data_wr   = wr_en && !addr;
    assign ctrl_wr   = wr_en && addr;
    assign done_clr  = (rd_en && !addr) || (ctrl_wr && wdata[3]);
    assign lat_done  = (state == ST_LAUNCH) && (lat_q == LAT_END);
    assign last_half = (half_q == LAST_HALF);
    assign half_nx   = half_q + HONE;
    assign do_shift  = (state == ST_RUN) && tick && !last_half && !half_nx[0];
    assign do_sample = (state == ST_RUN) && tick && !last_half &&  half_nx[0];
    assign busy      = (state != ST_IDLE);

    spi_phase_timer #(.DIVW(DIVW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (lat_done),
        .en    (state == ST_RUN),
        .limit (div_q),
        .tick  (tick)
    );

    spi_shift_core #(.W(DATA_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     ((state == ST_IDLE) && data_wr),
        .load_val (wdata),
        .shift    (do_shift),
        .sample   (do_sample),
        .din      (miso),
        .tx_msb   (tx_msb),
        .tx_next  (tx_next),
        .rx_word  (rx_word)
    );

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (data_wr)            state_nx = ST_LAUNCH;
            ST_LAUNCH: if (lat_done)           state_nx = ST_RUN;
            ST_RUN:    if (tick && last_half)  state_nx = ST_FINISH;
            ST_FINISH:                         state_nx = ST_IDLE;
            default:                           state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Outputs, configuration and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cpol_q   <= 1'b0;
            cpha_q   <= 1'b0;
            ie_q     <= 1'b0;
            done_q   <= 1'b0;
            sck_q    <= 1'b0;
            mosi_q   <= 1'b1;
            lat_q    <= '0;
            half_q   <= '0;
            div_q    <= DIVW'(1);
            rx_buf_q <= '0;
        end else begin
            lat_q <= (state == ST_LAUNCH) ? lat_q + LONE : '0;

            if (ctrl_wr) begin
                ie_q <= wdata[2];
                if (state == ST_IDLE) begin
                    cpol_q <= wdata[0];
                    cpha_q <= wdata[1];
                    sck_q  <= wdata[0];
                end
            end

            if ((state == ST_IDLE) && data_wr)
                div_q <= (half_div == '0) ? DIVW'(1) : half_div;

            if (lat_done) begin
                half_q <= '0;
                sck_q  <= cpol_q ^ cpha_q;
                mosi_q <= tx_msb;
            end

            if ((state == ST_RUN) && tick) begin
                if (last_half) begin
                    sck_q    <= cpol_q;
                    mosi_q   <= 1'b1;
                    rx_buf_q <= rx_word;
                end else begin
                    half_q <= half_nx;
                    sck_q  <= cpol_q ^ cpha_q ^ half_nx[0];
                    if (!half_nx[0]) mosi_q <= tx_next;
                end
            end

            if (state == ST_FINISH) done_q <= 1'b1;
            else if (done_clr)      done_q <= 1'b0;
        end
    end

    assign sck  = sck_q;
    assign mosi = mosi_q;
    assign irq  = done_q && ie_q;

    always_comb begin
        rdata = '0;
        if (!addr) begin
            rdata = rx_buf_q;
        end else begin
            rdata[0] = cpol_q;
            rdata[1] = cpha_q;
            rdata[2] = ie_q;
            rdata[3] = done_q;
            rdata[4] = busy;
        end
    end
endmodule

// File: rtl/spi_byte_master_chk.sv
module spi_byte_master_chk
    import spi_byte_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input xfer_state_t state,
    input logic        wr_en,
    input logic        addr,
    input logic        sck,
    input logic        mosi,
    input logic        irq,
    input logic        cpol_q,
    input logic        done_q
);
    a_r1_idle_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) && !(wr_en && !addr) |=> (state == ST_IDLE));

    a_r2_sck_rests_at_polarity: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (sck == cpol_q));

    a_r4_mosi_parked_high: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE || state == ST_LAUNCH) |-> mosi);

    a_r7_done_follows_finish: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> ($past(state) == ST_FINISH));

    a_r8_irq_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> done_q);

    a_r10_busy_write_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN || state == ST_FINISH) && wr_en && !addr |=> (state != ST_LAUNCH));
endmodule

bind spi_byte_master spi_byte_master_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .state  (state),
    .wr_en  (wr_en),
    .addr   (addr),
    .sck    (sck),
    .mosi   (mosi),
    .irq    (irq),
    .cpol_q (cpol_q),
    .done_q (done_q)
);

// File: tb/spi_byte_master_test.sv
`timescale 1ns/1ps
module spi_byte_master_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic       addr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [7:0] half_div = 8'd1;
    logic       sck, mosi, irq;
    logic       miso = 1'b1;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    spi_byte_master uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .half_div(half_div), .sck(sck),
        .mosi(mosi), .miso(miso), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic peek(input logic a, output logic [7:0] d);
        addr = a;
        #0.5;
        d = rdata;
    endtask

    task automatic reg_write(input logic a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; addr = 1'b0;
    endtask

    task automatic count_idle_edges(input int cycles, output int n);
        logic p;
        n = 0;
        p = sck;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (sck != p) n++;
            p = sck;
        end
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(sck == 1'b0, "R2 reset sck", sck, 0);
        check(mosi == 1'b1, "R4 reset mosi", mosi, 1);
        check(irq == 1'b0, "R8 reset irq", irq, 0);
        peek(1'b1, d);
        check(d == 8'h00, "R9 reset status", d, 0);
        peek(1'b0, d);
        check(d == 8'h00, "R7 reset buffer", d, 0);
    endtask

    task automatic t_transfer(input bit cpol, input bit cpha, input logic [7:0] div,
                              input logic [7:0] tx, input logic [7:0] slv,
                              input bit ie, input int poke_at);
        logic [7:0] d;
        logic [7:0] got;
        logic p;
        int h, k, first, edges, jdone, j, idle_n;
        h = (div == 0) ? 1 : int'(div);
        reg_write(1'b1, {4'b0000, 1'b1, ie, cpha, cpol});
        check(sck == cpol, "R2 sck at polarity before transfer", sck, cpol);
        half_div = div;
        k = 0; first = -1; edges = 0; jdone = -1; got = '0;
        miso = slv[7];
        reg_write(1'b0, tx);
        p = sck;
        j = 0;
        while (jdone < 0 && j < 20 * h + 40) begin
            if (j == poke_at + 1) wr_en = 1'b0;
            if (j == 2) begin
                check(mosi == 1'b1, "R4 mosi high during launch", mosi, 1);
                check(sck == cpol, "R3 sck idle during launch", sck, cpol);
            end
            if (j == 3) check(mosi == tx[7], "R3 msb at third clock", mosi, tx[7]);
            if (sck != p) begin
                edges++;
                if (first < 0) first = j;
                if ((cpha == 1'b0 && sck != cpol) || (cpha == 1'b1 && sck == cpol)) begin
                    got = {got[6:0], mosi};
                    k++;
                    if (k < 8) miso = slv[7 - k];
                end
            end
            p = sck;
            if (j == 16 * h + 3) begin
                peek(1'b0, d);
                check(d == slv, "R7 buffer before done", d, slv);
                peek(1'b1, d);
                check(d[3] == 1'b0, "R7 done one clock after buffer", d[3], 0);
            end
            peek(1'b1, d);
            if (d[3]) jdone = j;
            if (j == poke_at) begin
                wr_en = 1'b1; addr = 1'b0; wdata = ~tx;
            end
            if (jdone < 0) begin
                @(negedge clk);
                j++;
            end
        end
        wr_en = 1'b0;
        check(first == (cpha ? 3 : 3 + h), "R3 first sck edge", first, cpha ? 3 : 3 + h);
        check(edges == 16, "R5 sck transitions", edges, 16);
        check(got == tx, "R6 msb-first bits on mosi", got, tx);
        check(jdone == 16 * h + 4, "R7 done latency", jdone, 16 * h + 4);
        check(irq == ie, "R8 irq follows enable", irq, ie);
        check(mosi == 1'b1 && sck == cpol, "R4 lines parked after", {sck, mosi}, {cpol, 1'b1});
        peek(1'b0, d);
        check(d == slv, "R6 received byte", d, slv);
        count_idle_edges(30, idle_n);
        check(idle_n == 0, "R10 no further transfer", idle_n, 0);
        peek(1'b1, d);
        check(d[4] == 1'b0, "R10 not busy afterwards", d[4], 0);
    endtask

    task automatic t_clear_by_read();
        logic [7:0] d;
        @(negedge clk);
        addr = 1'b0; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        peek(1'b1, d);
        check(d[3] == 1'b0, "R9 read clears done", d[3], 0);
        check(irq == 1'b0, "R9 irq drops after read", irq, 0);
    endtask

    task automatic t_clear_by_w1c();
        logic [7:0] d;
        peek(1'b1, d);
        check(d[3] == 1'b1, "R9 done set before clear", d[3], 1);
        reg_write(1'b1, 8'b0000_1100);
        peek(1'b1, d);
        check(d[3] == 1'b0, "R9 write-one clears done", d[3], 0);
    endtask

    task automatic t_no_start();
        int n;
        logic [7:0] d;
        reg_write(1'b1, 8'b0000_0010);
        @(negedge clk);
        addr = 1'b0; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        count_idle_edges(40, n);
        check(n == 0 && mosi == 1'b1, "R1 control write and read do not start", n, 0);
        peek(1'b1, d);
        check(d[4] == 1'b0, "R1 stays idle", d[4], 0);
    endtask

    initial begin
        #(4 * 200000);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_no_start();
        t_transfer(1'b0, 1'b0, 8'd1, 8'hA5, 8'h3C, 1'b1, -10);
        t_clear_by_read();
        t_transfer(1'b0, 1'b1, 8'd2, 8'h81, 8'h7E, 1'b0, -10);
        t_transfer(1'b1, 1'b0, 8'd3, 8'h5A, 8'hC3, 1'b1, -10);
        t_clear_by_w1c();
        t_transfer(1'b1, 1'b1, 8'd0, 8'h96, 8'h01, 1'b1, -10);
        t_clear_by_read();
        t_transfer(1'b0, 1'b0, 8'd2, 8'hF0, 8'h99, 1'b0, 9);
        t_transfer(1'b1, 1'b1, 8'd2, 8'h3B, 8'hE4, 1'b0, 30);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule